// File: doc/BRIEF.md
# Test Master Transfer Attributes and Address Stepper

This block keeps the transfer attributes that a bus master uses while it drives system test traffic: the transfer size, the four protection bits, the lock request and an enable for address stepping. Software-free test sequencers feed it 11-bit control words. Each word carries a valid flag, and the block commits the word only when that flag is set. The fields sit at fixed, scattered bit positions, and the block translates them into AHB-style attribute outputs that change on the clock edge that commits the word.

The block also produces the transfer address. A load strobe replaces the whole address with a new base. Each transfer-done pulse then advances the low byte of the address by the current transfer size, provided stepping is enabled, and the byte wraps within its 256-address window. With stepping disabled, repeated transfers go to the same location. This suits polling a single peripheral register. The lock output is a plain registered copy of the committed lock field. The sequencer must commit it one cycle ahead of the transfer it protects.

Top module: `tm_xfer_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the outputs are `hsize`=3'b010, `hprot`=4'b0011, `hlock`=0 and `haddr`=0, and address stepping is disabled.
- R2: A control word offered with bit 0 low changes nothing. All attribute outputs keep their values, and the stepping enable keeps its value, which is seen through the next transfer-done pulse.
- R3: A control word with bit 0 high is committed on that clock edge. Bits 3:2 give the size code, bit 4 the lock, bits 6:5 `hprot[1:0]`, bits 10:9 `hprot[3:2]` and bit 7 the stepping enable. Bits 1 and 8 have no effect.
- R4: `hsize[2]` is always 0. Size code 2'b11 is stored as 2'b10 (word), so only codes 00 (byte), 01 (halfword) and 10 (word) ever appear.
- R5: With stepping disabled, a transfer-done pulse leaves `haddr` unchanged.
- R6: With stepping enabled, a transfer-done pulse adds 1, 2 or 4 (for size code 00, 01 or 10) to `haddr[7:0]` modulo 256, while `haddr[31:8]` stays unchanged.
- R7: An address load replaces all 32 bits of `haddr` on the next edge and wins over a transfer-done pulse in the same cycle.
- R8: When a control word and a transfer-done pulse share a cycle, the step uses the size and stepping enable that were in force before that control word.
- R9: `hlock` changes only on the edge that commits a valid control word. It keeps its old value during the cycle in which the word is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word strobe |
| ctrl_word | input | 11 | Control word; bit 0 is the valid flag |
| addr_ld | input | 1 | Base address load strobe |
| addr_in | input | 32 | Base address to load |
| xfer_done | input | 1 | One-cycle pulse after each completed transfer |
| hsize | output | 3 | Transfer size |
| hprot | output | 4 | Protection attributes |
| hlock | output | 1 | Lock request |
| haddr | output | 32 | Transfer address |

## Verification
Two pairs of functions can fall in the same edge: an address load against a step, and a control commit against a step. The bench drives each pair in one cycle on purpose. It loads a new base while pulsing transfer-done and expects the loaded value exactly. It also commits a new size or enable alongside transfer-done, and expects the step to follow the old attributes, with the new ones first used on the following pulse. Byte-boundary wrap is provoked by starting the low byte near 0xFF, so the step and the commit land on the wrap.

// File: rtl/tm_xfer_pkg.sv
package tm_xfer_pkg;

    localparam int CTRL_W = 11;

    // Control word bit positions; fixed because the sequencer encodes them.
    localparam int CW_VALID   = 0;
    localparam int CW_SIZE_LO = 2;
    localparam int CW_LOCK    = 4;
    localparam int CW_PROT_LO = 5;
    localparam int CW_STEP_EN = 7;
    localparam int CW_PROT_HI = 9;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } xfer_size_e;

    typedef struct packed {
        xfer_size_e  size;
        logic [3:0]  prot;
        logic        lock;
        logic        step_en;
    } xfer_attr_t;

    localparam xfer_attr_t ATTR_RESET = '{
        size:    SZ_WORD,
        prot:    4'b0011,
        lock:    1'b0,
        step_en: 1'b0
    };

    // Unsupported code 2'b11 is folded onto a word transfer.
    function automatic xfer_size_e legal_size(input logic [1:0] code);
        case (code)
            2'b00:   return SZ_BYTE;
            2'b01:   return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

endpackage

// File: rtl/tm_attr_reg.sv
module tm_attr_reg
    import tm_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    output xfer_attr_t        attr
);

    xfer_attr_t decoded;
    logic       commit;
    logic       reserved_unused;

    assign reserved_unused = ^{ctrl_word[1], ctrl_word[8]};
    assign commit = ctrl_wr && ctrl_word[CW_VALID];

    always_comb begin
        decoded.size    = legal_size(ctrl_word[CW_SIZE_LO +: 2]);
        decoded.prot    = {ctrl_word[CW_PROT_HI +: 2], ctrl_word[CW_PROT_LO +: 2]};
        decoded.lock    = ctrl_word[CW_LOCK];
        decoded.step_en = ctrl_word[CW_STEP_EN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            attr <= ATTR_RESET;
        end else if (commit) begin
            attr <= decoded;
        end
    end

endmodule

// File: rtl/tm_addr_gen.sv
module tm_addr_gen
    import tm_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              xfer_done,
    input  logic              step_en,
    input  xfer_size_e        size,
    output logic [ADDR_W-1:0] haddr
);

    localparam int SW = (STEP_W < ADDR_W) ? STEP_W : ADDR_W;

    logic [SW-1:0]     step;
    logic [SW-1:0]     low_next;
    logic [ADDR_W-1:0] stepped;

    assign step     = SW'(1) << size;
    assign low_next = haddr[SW-1:0] + step;

    generate
        if (SW < ADDR_W) begin : g_split
            assign stepped = {haddr[ADDR_W-1:SW], low_next};
        end else begin : g_full
            assign stepped = low_next;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            haddr <= '0;
        end else if (addr_ld) begin
            haddr <= addr_in;
        end else if (xfer_done && step_en) begin
            haddr <= stepped;
        end
    end

endmodule

// File: rtl/tm_xfer_ctrl.sv
module tm_xfer_ctrl
    import tm_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [10:0]       ctrl_word,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              xfer_done,
    output logic [2:0]        hsize,
    output logic [3:0]        hprot,
    output logic              hlock,
    output logic [ADDR_W-1:0] haddr
);

    xfer_attr_t attr;

    tm_attr_reg u_attr (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_word (ctrl_word),
        .attr      (attr)
    );

    tm_addr_gen #(
        .ADDR_W (ADDR_W),
        .STEP_W (STEP_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .addr_ld   (addr_ld),
        .addr_in   (addr_in),
        .xfer_done (xfer_done),
        .step_en   (attr.step_en),
        .size      (attr.size),
        .haddr     (haddr)
    );

    assign hsize = {1'b0, attr.size};
    assign hprot = attr.prot;
    assign hlock = attr.lock;

endmodule

// File: rtl/tm_xfer_ctrl_chk.sv
module tm_xfer_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_wr,
    input logic [10:0]       ctrl_word,
    input logic              addr_ld,
    input logic [ADDR_W-1:0] addr_in,
    input logic              xfer_done,
    input logic [2:0]        hsize,
    input logic [3:0]        hprot,
    input logic              hlock,
    input logic [ADDR_W-1:0] haddr
);

    logic bits_unused;
    assign bits_unused = ^{ctrl_word[1], ctrl_word[7], ctrl_word[8]};

    p_size_msb_low_r4: assert property (@(posedge clk) disable iff (rst)
        hsize[2] == 1'b0);

    p_size_legal_r4: assert property (@(posedge clk) disable iff (rst)
        hsize[1:0] != 2'b11);

    p_ignore_invalid_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_word[0]) |=> ($stable(hsize) && $stable(hprot) && $stable(hlock)));

    p_prot_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_word[0]) |=> (hprot == {$past(ctrl_word[10:9]), $past(ctrl_word[6:5])}));

    p_size_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_word[0] && ctrl_word[3:2] != 2'b11) |=> (hsize[1:0] == $past(ctrl_word[3:2])));

    p_lock_commit_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_word[0]) |=> (hlock == $past(ctrl_word[4])));

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_wr && ctrl_word[0]) |=> $stable(hlock));

    p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
        addr_ld |=> (haddr == $past(addr_in)));

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        !addr_ld |=> (haddr[ADDR_W-1:8] == $past(haddr[ADDR_W-1:8])));

    p_idle_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (!addr_ld && !xfer_done) |=> $stable(haddr));

endmodule

bind tm_xfer_ctrl tm_xfer_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_word (ctrl_word),
    .addr_ld   (addr_ld),
    .addr_in   (addr_in),
    .xfer_done (xfer_done),
    .hsize     (hsize),
    .hprot     (hprot),
    .hlock     (hlock),
    .haddr     (haddr)
);

// File: tb/tm_xfer_ctrl_bench.sv
module tm_xfer_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr = 1'b0;
    logic [10:0] ctrl_word = '0;
    logic        addr_ld = 1'b0;
    logic [31:0] addr_in = '0;
    logic        xfer_done = 1'b0;
    logic [2:0]  hsize;
    logic [3:0]  hprot;
    logic        hlock;
    logic [31:0] haddr;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_addr;

    always #2 clk = ~clk;

    tm_xfer_ctrl u_tm_xfer_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_word (ctrl_word),
        .addr_ld   (addr_ld),
        .addr_in   (addr_in),
        .xfer_done (xfer_done),
        .hsize     (hsize),
        .hprot     (hprot),
        .hlock     (hlock),
        .haddr     (haddr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, return at the next falling edge.
    task automatic cycle(input logic wr, input logic [10:0] w, input logic ld,
                         input logic [31:0] a, input logic done);
        ctrl_wr   = wr;
        ctrl_word = w;
        addr_ld   = ld;
        addr_in   = a;
        xfer_done = done;
        @(posedge clk);
        @(negedge clk);
        ctrl_wr   = 1'b0;
        addr_ld   = 1'b0;
        xfer_done = 1'b0;
    endtask

    function automatic logic [2:0] size_of(input logic [1:0] code);
        return (code == 2'b11) ? 3'b010 : {1'b0, code};
    endfunction

    function automatic logic [31:0] step_addr(input logic [31:0] a, input int sz);
        logic [7:0] lo;
        lo = a[7:0] + 8'(1 << sz);
        return {a[31:8], lo};
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [2:0]  e_size;
        logic [3:0]  e_prot;
        logic        e_lock;
        logic [10:0] w;

        // R1: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 hsize", hsize, 3'b010);
        check("R1 hprot", hprot, 4'b0011);
        check("R1 hlock", hlock, 1'b0);
        check("R1 haddr", haddr, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 attrs after release", {hsize, hprot, hlock}, {3'b010, 4'b0011, 1'b0});
        cycle(1'b0, 11'h0, 1'b0, 32'h0, 1'b1);
        check("R1 stepping off after reset", haddr, 32'h0);

        // R3/R4/R2: sweep every valid word, then an invalid word
        e_size = 3'b010; e_prot = 4'b0011; e_lock = 1'b0;
        for (int v = 0; v < 1024; v++) begin
            w = {v[9:0], 1'b1};
            cycle(1'b1, w, 1'b0, 32'h0, 1'b0);
            e_size = size_of(w[3:2]);
            e_prot = {w[10:9], w[6:5]};
            e_lock = w[4];
            check("R3 R4 field decode", {hsize, hprot, hlock}, {e_size, e_prot, e_lock});
            cycle(1'b1, {~v[9:0], 1'b0}, 1'b0, 32'h0, 1'b0);
            check("R2 invalid word ignored", {hsize, hprot, hlock}, {e_size, e_prot, e_lock});
        end

        // R5: stepping off (bit 7 low)
        cycle(1'b1, 11'h001, 1'b0, 32'h0, 1'b0);
        cycle(1'b0, 11'h0, 1'b1, 32'h1234_56FE, 1'b0);
        check("R7 load", haddr, 32'h1234_56FE);
        for (int i = 0; i < 5; i++) begin
            cycle(1'b0, 11'h0, 1'b0, 32'h0, 1'b1);
            check("R5 no step when disabled", haddr, 32'h1234_56FE);
        end

        // R6: stepping per size, with wrap of the low byte
        for (int s = 0; s < 3; s++) begin
            cycle(1'b1, 11'((s << 2) | (1 << 7) | 1), 1'b0, 32'h0, 1'b0);
            exp_addr = 32'hA5A5_5A00 + 32'(s * 8'h37);
            cycle(1'b0, 11'h0, 1'b1, exp_addr, 1'b0);
            for (int i = 0; i < 300; i++) begin
                cycle(1'b0, 11'h0, 1'b0, 32'h0, 1'b1);
                exp_addr = step_addr(exp_addr, s);
                check("R6 step", haddr, exp_addr);
                if (i % 50 == 7) begin
                    cycle(1'b0, 11'h0, 1'b0, 32'h0, 1'b0);
                    check("R6 idle keeps address", haddr, exp_addr);
                end
            end
        end

        // R2: invalid word with bit 7 low leaves stepping enabled (word size)
        cycle(1'b1, 11'h000, 1'b0, 32'h0, 1'b0);
        cycle(1'b0, 11'h0, 1'b0, 32'h0, 1'b1);
        exp_addr = step_addr(exp_addr, 2);
        check("R2 stepping enable kept", haddr, exp_addr);

        // R7: load together with transfer-done
        cycle(1'b0, 11'h0, 1'b1, 32'h0F0F_F0FC, 1'b1);
        check("R7 load wins over step", haddr, 32'h0F0F_F0FC);

        // R8: control commit and step in the same cycle
        cycle(1'b1, 11'h081, 1'b0, 32'h0, 1'b0);
        cycle(1'b0, 11'h0, 1'b1, 32'h1000_00FF, 1'b0);
        cycle(1'b1, 11'h089, 1'b0, 32'h0, 1'b1);
        check("R8 step uses old byte size", haddr, 32'h1000_0000);
        check("R8 new size visible", hsize, 3'b010);
        cycle(1'b0, 11'h0, 1'b0, 32'h0, 1'b1);
        check("R8 next step uses word size", haddr, 32'h1000_0004);
        cycle(1'b1, 11'h009, 1'b0, 32'h0, 1'b1);
        check("R8 step uses old enable", haddr, 32'h1000_0008);
        cycle(1'b0, 11'h0, 1'b0, 32'h0, 1'b1);
        check("R8 disable then takes effect", haddr, 32'h1000_0008);
        cycle(1'b1, 11'h089, 1'b0, 32'h0, 1'b1);
        check("R8 enable does not step same cycle", haddr, 32'h1000_0008);

        // R9: lock timing
        cycle(1'b1, 11'h001, 1'b0, 32'h0, 1'b0);
        ctrl_wr = 1'b1;
        ctrl_word = 11'h011;
        #1;
        check("R9 lock holds while word offered", hlock, 1'b0);
        @(posedge clk);
        @(negedge clk);
        ctrl_wr = 1'b0;
        check("R9 lock after commit edge", hlock, 1'b1);
        cycle(1'b0, 11'h0, 1'b0, 32'h0, 1'b1);
        check("R9 lock stays without commit", hlock, 1'b1);
        cycle(1'b1, 11'h010, 1'b0, 32'h0, 1'b0);
        check("R9 invalid word keeps lock", hlock, 1'b1);
        cycle(1'b1, 11'h001, 1'b0, 32'h0, 1'b0);
        check("R9 lock cleared by commit", hlock, 1'b0);

        finish_run();
    end

endmodule